// File: doc/BRIEF.md
# Bit-Enabled Control Register Bank

This block holds a small set of control words behind a plain memory-mapped write and read port. Each control word carries 16 usable bits in its lower half. The upper half of every write word does not hold data. Each of its bits is a write enable for the bit exactly 16 positions below it. Software can therefore change one field of a shared register with a single write. A read-modify-write is not needed, and fields that other agents own are left alone.

The stored bits of all control words drive parallel outputs to the logic being configured. One extra word offset is a read-only status word. Its low 8 bits return the value of a status input, sampled when the read is accepted. Writes take effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read request.

Top module: `ctl_regbank`

## Requirements
- R1: While reset is high, every control bit and the read data clear to zero on each clock edge.
- R2: On a write to control offset k (word offsets 0 to NUM_CTRL-1), stored bit i of word k takes wr_data[i] when wr_data[i+16] is 1.
- R3: On such a write, every stored bit i whose enable wr_data[i+16] is 0 keeps its previous value.
- R4: A field of width W (1 to 8) at bit position s is written alone with value v<<s and enable ((1<<W)-1)<<(s+16). In particular, four-bit fields at positions 0, 4, 8 and 12 of one word can each be updated without disturbing the others.
- R5: A read request to control offset k returns the stored 16 bits in rd_data[15:0] and zeros in rd_data[31:16], on the edge that accepts the request. Without a request, rd_data holds its value.
- R6: A read of the status offset (word offset NUM_CTRL, 4 by default) returns status_in as sampled at the accepting edge in rd_data[7:0], with all other bits zero.
- R7: A write to the status offset, or to any offset above it, changes no control bit.
- R8: A read of any offset above the status offset returns zero.
- R9: ctrl_out[16k+15:16k] always shows the stored bits of word k, updated on the edge that accepts the write.
- R10: When a read and a write address the same word in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W (3) | Word offset of the write |
| wr_data | input | 32 | [15:0] new bit values, [31:16] per-bit enables |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W (3) | Word offset of the read |
| rd_data | output | 32 | Registered read data |
| status_in | input | STAT_W (8) | Value returned by the status word |
| ctrl_out | output | 16*NUM_CTRL (64) | Stored control bits, word k at [16k+15:16k] |

## Verification
The bench targets partial enables: sparse and alternating masks, a zero mask, and single-bit and eight-bit fields at several positions. A design that ignores the upper half would clobber neighbouring fields. A design that stores the enable bits would return non-zero upper read data. The bench also writes to the status offset and to unmapped offsets, where a loose decoder would alias onto a control word. It reads and writes the same word in one cycle, where a bypassed read would return the new value instead of the old. It also changes status_in after a read, where unregistered read data would follow the input.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    // Write word split: enables in the upper half, values in the lower half.
    typedef struct packed {
        logic [HALF_W-1:0] en;
        logic [HALF_W-1:0] val;
    } wr_word_t;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_CTRL   = 2'd1,
        RD_STATUS = 2'd2
    } rd_kind_e;

    function automatic logic [HALF_W-1:0] masked_update(
        input logic [HALF_W-1:0] old_bits,
        input wr_word_t          w
    );
        return (old_bits & ~w.en) | (w.val & w.en);
    endfunction

endpackage

// File: rtl/ctl_regbank_decode.sv
module ctl_regbank_decode
    import ctl_regbank_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int ADDR_W   = 3,
    parameter int IDX_W    = 2
) (
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [NUM_CTRL-1:0] wr_sel,
    output rd_kind_e            rd_kind,
    output logic [IDX_W-1:0]    rd_idx
);
    localparam int STATUS_OFS = NUM_CTRL;

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_wsel
        assign wr_sel[k] = wr_valid && (wr_addr == ADDR_W'(k));
    end

    always_comb begin
        rd_idx = rd_addr[IDX_W-1:0];
        if (int'(rd_addr) < NUM_CTRL) begin
            rd_kind = RD_CTRL;
        end else if (rd_addr == ADDR_W'(STATUS_OFS)) begin
            rd_kind = RD_STATUS;
        end else begin
            rd_kind = RD_NONE;
        end
    end

endmodule

// File: rtl/ctl_regbank_cell.sv
module ctl_regbank_cell
    import ctl_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  wr_word_t          wr_word,
    output logic [HALF_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= masked_update(q, wr_word);
        end
    end

    // R1: reset clears the stored bits
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2: enabled bits take the written value
    assert_enabled_take_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (((q ^ $past(wr_word.val)) & $past(wr_word.en)) == '0));

    // R3: disabled bits keep their value
    assert_masked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (((q ^ $past(q)) & ~$past(wr_word.en)) == '0));

    // R3: no write, no change
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/ctl_regbank_rdport.sv
module ctl_regbank_rdport
    import ctl_regbank_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int STAT_W   = 8,
    parameter int IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_req,
    input  rd_kind_e                   rd_kind,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [NUM_CTRL*HALF_W-1:0] ctrl_flat,
    input  logic [STAT_W-1:0]          status_in,
    output logic [WORD_W-1:0]          rd_data
);
    logic [HALF_W-1:0] words [NUM_CTRL];
    logic [WORD_W-1:0] rd_next;

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_words
        assign words[k] = ctrl_flat[k*HALF_W +: HALF_W];
    end

    always_comb begin
        rd_next = '0;
        case (rd_kind)
            RD_CTRL:   rd_next[HALF_W-1:0] = words[rd_idx];
            RD_STATUS: rd_next[STAT_W-1:0] = status_in;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= rd_next;
        end
    end

    // R5: upper half of any read result is zero
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (rd_data[WORD_W-1:HALF_W] == '0));

    // R5: read data holds without a request
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_data));

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import ctl_regbank_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int ADDR_W   = 3,
    parameter int STAT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       rd_req,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [WORD_W-1:0]          rd_data,
    input  logic [STAT_W-1:0]          status_in,
    output logic [NUM_CTRL*HALF_W-1:0] ctrl_out
);
    localparam int IDX_W      = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;
    localparam int STATUS_OFS = NUM_CTRL;

    logic [NUM_CTRL-1:0] wr_sel;
    rd_kind_e            rd_kind;
    logic [IDX_W-1:0]    rd_idx;
    wr_word_t            wr_word;

    assign wr_word = wr_word_t'(wr_data);

    ctl_regbank_decode #(
        .NUM_CTRL (NUM_CTRL),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_decode (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .wr_sel   (wr_sel),
        .rd_kind  (rd_kind),
        .rd_idx   (rd_idx)
    );

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_cell
        ctl_regbank_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .we      (wr_sel[k]),
            .wr_word (wr_word),
            .q       (ctrl_out[k*HALF_W +: HALF_W])
        );
    end

    ctl_regbank_rdport #(
        .NUM_CTRL (NUM_CTRL),
        .STAT_W   (STAT_W),
        .IDX_W    (IDX_W)
    ) u_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .rd_kind   (rd_kind),
        .rd_idx    (rd_idx),
        .ctrl_flat (ctrl_out),
        .status_in (status_in),
        .rd_data   (rd_data)
    );

    // R7: writes at or above the status offset leave all control bits alone
    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && int'(wr_addr) >= STATUS_OFS) |=> $stable(ctrl_out));

    // R6: status read returns the sampled input, zero-extended
    assert_status_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_addr == ADDR_W'(STATUS_OFS))
        |=> (rd_data == WORD_W'($past(status_in))));

    // R8: reads above the status offset return zero
    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && int'(rd_addr) > STATUS_OFS) |=> (rd_data == '0));

endmodule

// File: tb/ctl_regbank_bench.sv
module ctl_regbank_bench;

    localparam int NUM_CTRL = 4;
    localparam int ADDR_W   = 3;
    localparam int STAT_W   = 8;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   wr_valid = 1'b0;
    logic [ADDR_W-1:0]      wr_addr = '0;
    logic [31:0]            wr_data = '0;
    logic                   rd_req = 1'b0;
    logic [ADDR_W-1:0]      rd_addr = '0;
    logic [31:0]            rd_data;
    logic [STAT_W-1:0]      status_in = '0;
    logic [NUM_CTRL*16-1:0] ctrl_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [15:0] model [NUM_CTRL];

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    ctl_regbank #(
        .NUM_CTRL (NUM_CTRL),
        .ADDR_W   (ADDR_W),
        .STAT_W   (STAT_W)
    ) u_ctl_regbank (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .status_in (status_in),
        .ctrl_out  (ctrl_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [15:0] old, input logic [31:0] d);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = d[i+16] ? d[i] : old[i];
        return r;
    endfunction

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < NUM_CTRL; k++) f[k*16 +: 16] = model[k];
        return f;
    endfunction

    function automatic logic [31:0] read_expect(input logic [ADDR_W-1:0] a);
        if (int'(a) < NUM_CTRL) return {16'h0, model[a]};
        if (int'(a) == NUM_CTRL) return {24'h0, status_in};
        return 32'h0;
    endfunction

    // monitor: rd_req was held across the last rising edge
    always @(negedge clk) begin
        if (!rst && rd_req) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, {32'h0, rd_data}, {32'h0, it.exp});
            end
        end
    end

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        @(negedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        if (int'(a) < NUM_CTRL) model[a] = expect_word(model[a], d);
        @(negedge clk);
        check(tag, ctrl_out, model_flat());
        #1 wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
        item_t it;
        @(negedge clk); #1;
        rd_req = 1'b1; rd_addr = a;
        it.exp = read_expect(a); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic do_rw(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        item_t it;
        @(negedge clk); #1;
        rd_req = 1'b1; rd_addr = a;
        it.exp = read_expect(a); it.tag = tag;
        sb_q.push_back(it);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        if (int'(a) < NUM_CTRL) model[a] = expect_word(model[a], d);
        @(negedge clk); #1;
        rd_req = 1'b0; wr_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NUM_CTRL; k++) model[k] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 reset ctrl_out", ctrl_out, 64'h0);
        check("R1 reset rd_data", {32'h0, rd_data}, 64'h0);
        #1 rst = 1'b0;

        // R2: full enable writes
        do_write(3'd0, 32'hFFFF_A5C3, "R2 full write w0");
        do_write(3'd1, 32'hFFFF_1234, "R2 full write w1");
        do_read(3'd0, "R5 read w0");
        do_read(3'd1, "R5 read w1");

        // R3: zero enables and sparse enables
        do_write(3'd0, 32'h0000_0000, "R3 zero mask no change");
        do_write(3'd0, 32'hAAAA_0000, "R3 alternate mask clears odd bits");
        do_write(3'd1, 32'h0101_FFFF, "R3 sparse mask sets two bits");
        do_read(3'd1, "R3 read back sparse");

        // R4: four-bit lane fields at 0,4,8,12
        for (int s = 0; s < 16; s += 4) begin
            do_write(3'd2, (32'hF << (s + 16)) | (32'(s/4 + 9) << s), "R4 lane field write");
        end
        do_read(3'd2, "R4 lane fields read");
        // R4: widths 1..8 at various positions
        for (int w = 1; w <= 8; w++) begin
            int s;
            s = (w * 3) % (17 - w);
            do_write(3'd3, ((((32'd1 << w) - 1)) << (s + 16)) | ((32'h5A & ((32'd1 << w) - 1)) << s),
                     "R4 width field write");
        end
        do_read(3'd3, "R4 width fields read");

        // R9: ctrl_out layout checked after every write; plain check here
        check("R9 ctrl_out layout", ctrl_out, model_flat());

        // R6: status read and hold
        status_in = 8'hA5;
        do_read(3'd4, "R6 status read");
        status_in = 8'h3C;
        @(negedge clk);
        check("R5 rd_data holds without request", {32'h0, rd_data}, 64'h0000_0000_0000_00A5);
        do_read(3'd4, "R6 status read new value");

        // R7: writes to status and unmapped offsets
        do_write(3'd4, 32'hFFFF_FFFF, "R7 status write ignored");
        do_write(3'd5, 32'hFFFF_0000, "R7 offset 5 write ignored");
        do_write(3'd7, 32'hFFFF_BEEF, "R7 offset 7 write ignored");

        // R8: unmapped reads
        do_read(3'd5, "R8 read offset 5");
        do_read(3'd6, "R8 read offset 6");
        do_read(3'd7, "R8 read offset 7");

        // R10: same-cycle read and write returns old value
        do_rw(3'd1, 32'hFFFF_0F0F, "R10 read before write");
        do_read(3'd1, "R10 new value after write");
        check("R9 ctrl_out after rw", ctrl_out, model_flat());

        // R1: reset mid-run clears everything
        @(negedge clk); #1 rst = 1'b1;
        for (int k = 0; k < NUM_CTRL; k++) model[k] = 16'h0;
        @(negedge clk);
        check("R1 reset clears ctrl_out", ctrl_out, 64'h0);
        check("R1 reset clears rd_data", {32'h0, rd_data}, 64'h0);
        #1 rst = 1'b0;
        do_read(3'd0, "R1 read after reset");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule